// File: doc/BRIEF.md
# Memory-Mapped General-Purpose Register File

This block holds the thirty-two 8-bit working registers of a small 8-bit processor core. Two read ports return operands without a clock, so an instruction can read its sources, compute and write back within one cycle. One instruction write port commits the result.

The same storage is also reachable as the bottom of the data address space. A load or store whose address is below 32 is decoded here and reaches register n at address n. Any higher address is flagged as belonging to someone else and is not acted on. The six highest registers are grouped into three 16-bit address pointers, named X, Y and Z. Their values go out continuously for indirect addressing. Each pointer has a 16-bit write path, so both bytes can be replaced in one cycle, for example by an auto-increment or auto-decrement. When several write sources aim at the same register in one cycle, a fixed priority decides which one lands.

Top module: `gpr_file`

## Requirements
- R1: After reset, every register reads as 0x00.
- R2: Both operand read ports return the current content of the selected register (selects 0 to 31) combinationally, independently of each other.
- R3: An instruction write (`insn_we`=1) stores `insn_wdata` into register `insn_wsel` at the next rising clock edge. A read of that register in the same cycle still returns the old value, because there is no bypass.
- R4: When `ds_re`=1 and `ds_addr` is below 32, `ds_rdata` returns register `ds_addr` and `ds_hit` is 1.
- R5: When `ds_we`=1 and `ds_addr` is below 32, register `ds_addr` takes `ds_wdata` at the next rising edge.
- R6: `ptr_x` equals {reg27, reg26}, `ptr_y` equals {reg29, reg28} and `ptr_z` equals {reg31, reg30}. The high byte is in the odd register.
- R7: With `ptr_we`=1, `ptr_wsel` picks the pointer (0 is X, 1 is Y, 2 is Z), and both bytes take `ptr_wdata` at the same edge. `ptr_wsel`=3 changes nothing.
- R8: When write sources hit the same register in one cycle, the instruction write beats the pointer write, and the pointer write beats the data-space write. Each register byte is resolved on its own.
- R9: A data-space access with `ds_addr` of 32 or more sets `ds_miss`=1 and `ds_hit`=0, drives `ds_rdata` to 0x00, and leaves every register unchanged, including the one whose index equals the low address bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| rda_sel | input | 5 | Operand port A register select |
| rda_data | output | 8 | Operand port A data |
| rdb_sel | input | 5 | Operand port B register select |
| rdb_data | output | 8 | Operand port B data |
| insn_we | input | 1 | Instruction result write enable |
| insn_wsel | input | 5 | Instruction result register |
| insn_wdata | input | 8 | Instruction result data |
| ptr_we | input | 1 | Pointer 16-bit write enable |
| ptr_wsel | input | 2 | Pointer select: 0 X, 1 Y, 2 Z |
| ptr_wdata | input | 16 | New pointer value |
| ds_addr | input | 16 | Data-space address |
| ds_re | input | 1 | Data-space read strobe |
| ds_we | input | 1 | Data-space write strobe |
| ds_wdata | input | 8 | Data-space write data |
| ds_rdata | output | 8 | Data-space read data, 0x00 unless a read hits the file |
| ds_hit | output | 1 | Access strobed and address below 32 |
| ds_miss | output | 1 | Access strobed and address at or above 32 |
| ptr_x | output | 16 | X pointer value |
| ptr_y | output | 16 | Y pointer value |
| ptr_z | output | 16 | Z pointer value |

## Verification
The embedded properties assume that every input is held at a known value while reset is asserted and during the cycle in which it is released. The write-landing checks only then have a defined previous cycle to refer to. The bench drives every strobe low from time zero until reset has been released for several cycles. It also changes inputs only a couple of nanoseconds after a rising edge, so the operand, pointer and data-space inputs are settled whenever a property samples them.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
  localparam int GPR_COUNT   = 32;
  localparam int GPR_W       = 8;
  localparam int DS_ADDR_W   = 16;
  localparam int PTR_BASE    = 26;
  localparam int PTR_COUNT   = 3;
  localparam int GPR_SEL_W   = $clog2(GPR_COUNT);
  localparam int PTR_SEL_W   = $clog2(PTR_COUNT + 1);
endpackage

// File: rtl/gpr_rst_sync.sv
module gpr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;
endmodule

// File: rtl/gpr_dspace_dec.sv
module gpr_dspace_dec #(
  parameter int AW    = 16,
  parameter int NREG  = 32,
  parameter int SEL_W = 5
) (
  input  logic [AW-1:0]    addr,
  input  logic             re,
  input  logic             we,
  output logic             hit,
  output logic             miss,
  output logic             rd_hit,
  output logic             wr_hit,
  output logic [SEL_W-1:0] idx
);
  logic in_range;
  logic strobe;

  always_comb begin
    in_range = (addr < AW'(NREG));
    strobe   = re | we;
    hit      = strobe & in_range;
    miss     = strobe & ~in_range;
    rd_hit   = re & in_range;
    wr_hit   = we & in_range;
    idx      = addr[SEL_W-1:0];
  end

  always_comb begin
    a_r9_hit_miss_exclusive : assert (!(hit && miss));
  end
endmodule

// File: rtl/gpr_read_port.sv
module gpr_read_port #(
  parameter int NREG  = 32,
  parameter int DW    = 8,
  parameter int SEL_W = 5
) (
  input  logic [NREG*DW-1:0] regs_flat,
  input  logic [SEL_W-1:0]   sel,
  output logic [DW-1:0]      data
);
  always_comb begin
    data = regs_flat[sel*DW +: DW];
  end
endmodule

// File: rtl/gpr_cell_next.sv
module gpr_cell_next #(
  parameter int IDX   = 0,
  parameter int DW    = 8,
  parameter int SEL_W = 5
) (
  input  logic             insn_we,
  input  logic [SEL_W-1:0] insn_sel,
  input  logic [DW-1:0]    insn_d,
  input  logic             ptr_hit,
  input  logic [DW-1:0]    ptr_d,
  input  logic             ds_we,
  input  logic [SEL_W-1:0] ds_sel,
  input  logic [DW-1:0]    ds_d,
  output logic             we,
  output logic [DW-1:0]    d
);
  logic insn_hit;
  logic ds_hit;

  always_comb begin
    insn_hit = insn_we && (insn_sel == SEL_W'(IDX));
    ds_hit   = ds_we && (ds_sel == SEL_W'(IDX));
    we = 1'b0;
    d  = '0;
    if (insn_hit) begin
      we = 1'b1;
      d  = insn_d;
    end else if (ptr_hit) begin
      we = 1'b1;
      d  = ptr_d;
    end else if (ds_hit) begin
      we = 1'b1;
      d  = ds_d;
    end
  end
endmodule

// File: rtl/gpr_file.sv
module gpr_file
  import gpr_pkg::*;
#(
  parameter int NREG   = GPR_COUNT,
  parameter int DW     = GPR_W,
  parameter int AW     = DS_ADDR_W,
  parameter int PBASE  = PTR_BASE,
  parameter int PCOUNT = PTR_COUNT
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [$clog2(NREG)-1:0]     rda_sel,
  output logic [DW-1:0]               rda_data,
  input  logic [$clog2(NREG)-1:0]     rdb_sel,
  output logic [DW-1:0]               rdb_data,
  input  logic                        insn_we,
  input  logic [$clog2(NREG)-1:0]     insn_wsel,
  input  logic [DW-1:0]               insn_wdata,
  input  logic                        ptr_we,
  input  logic [$clog2(PCOUNT+1)-1:0] ptr_wsel,
  input  logic [2*DW-1:0]             ptr_wdata,
  input  logic [AW-1:0]               ds_addr,
  input  logic                        ds_re,
  input  logic                        ds_we,
  input  logic [DW-1:0]               ds_wdata,
  output logic [DW-1:0]               ds_rdata,
  output logic                        ds_hit,
  output logic                        ds_miss,
  output logic [2*DW-1:0]             ptr_x,
  output logic [2*DW-1:0]             ptr_y,
  output logic [2*DW-1:0]             ptr_z
);
  localparam int SEL_W  = $clog2(NREG);
  localparam int PSEL_W = $clog2(PCOUNT + 1);

  logic                rst_q_n;
  logic [DW-1:0]       regs_q [NREG];
  logic [NREG*DW-1:0]  regs_flat;
  logic [NREG-1:0]     reg_we;
  logic [DW-1:0]       reg_d  [NREG];
  logic                ds_rd_hit;
  logic                ds_wr_hit;
  logic [SEL_W-1:0]    ds_idx;
  logic [DW-1:0]       ds_raw;

  gpr_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  gpr_dspace_dec #(.AW(AW), .NREG(NREG), .SEL_W(SEL_W)) u_dec (
    .addr   (ds_addr),
    .re     (ds_re),
    .we     (ds_we),
    .hit    (ds_hit),
    .miss   (ds_miss),
    .rd_hit (ds_rd_hit),
    .wr_hit (ds_wr_hit),
    .idx    (ds_idx)
  );

  // Next-state logic: one priority cell per register
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic          p_hit;
    logic [DW-1:0] p_byte;
    if (i >= PBASE && i < PBASE + 2*PCOUNT) begin : g_ptr
      assign p_hit  = ptr_we && (ptr_wsel == PSEL_W'((i - PBASE) / 2));
      assign p_byte = ptr_wdata[((i - PBASE) % 2)*DW +: DW];
    end else begin : g_plain
      assign p_hit  = 1'b0;
      assign p_byte = '0;
    end
    gpr_cell_next #(.IDX(i), .DW(DW), .SEL_W(SEL_W)) u_cell (
      .insn_we  (insn_we),
      .insn_sel (insn_wsel),
      .insn_d   (insn_wdata),
      .ptr_hit  (p_hit),
      .ptr_d    (p_byte),
      .ds_we    (ds_wr_hit),
      .ds_sel   (ds_idx),
      .ds_d     (ds_wdata),
      .we       (reg_we[i]),
      .d        (reg_d[i])
    );
  end

  // Storage with per-register clock enables
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      for (int k = 0; k < NREG; k++) regs_q[k] <= '0;
    end else begin
      for (int k = 0; k < NREG; k++) begin
        if (reg_we[k]) regs_q[k] <= reg_d[k];
      end
    end
  end

  always_comb begin
    for (int k = 0; k < NREG; k++) regs_flat[k*DW +: DW] = regs_q[k];
  end

  gpr_read_port #(.NREG(NREG), .DW(DW), .SEL_W(SEL_W)) u_rda (
    .regs_flat (regs_flat), .sel (rda_sel), .data (rda_data)
  );
  gpr_read_port #(.NREG(NREG), .DW(DW), .SEL_W(SEL_W)) u_rdb (
    .regs_flat (regs_flat), .sel (rdb_sel), .data (rdb_data)
  );
  gpr_read_port #(.NREG(NREG), .DW(DW), .SEL_W(SEL_W)) u_rds (
    .regs_flat (regs_flat), .sel (ds_idx), .data (ds_raw)
  );

  assign ds_rdata = ds_rd_hit ? ds_raw : '0;

  assign ptr_x = {regs_q[PBASE+1], regs_q[PBASE]};
  assign ptr_y = {regs_q[PBASE+3], regs_q[PBASE+2]};
  assign ptr_z = {regs_q[PBASE+5], regs_q[PBASE+4]};

  // Assertions
  a_r3_insn_write_lands : assert property (@(posedge clk) disable iff (!rst_q_n)
    insn_we |=> regs_q[$past(insn_wsel)] == $past(insn_wdata));

  a_r5_ds_write_lands : assert property (@(posedge clk) disable iff (!rst_q_n)
    (ds_we && ds_hit && !insn_we && !ptr_we) |=> regs_q[$past(ds_idx)] == $past(ds_wdata));

  a_r7_ptr_z_both_bytes : assert property (@(posedge clk) disable iff (!rst_q_n)
    (ptr_we && ptr_wsel == PSEL_W'(2) && !insn_we) |=> ptr_z == $past(ptr_wdata));

  a_r8_insn_beats_ds : assert property (@(posedge clk) disable iff (!rst_q_n)
    (insn_we && ds_we && ds_hit && ds_idx == insn_wsel)
      |=> regs_q[$past(insn_wsel)] == $past(insn_wdata));

  a_r9_miss_no_change : assert property (@(posedge clk) disable iff (!rst_q_n)
    (ds_we && ds_miss && !insn_we && !ptr_we) |=> $stable(regs_flat));

  a_r9_miss_reads_zero : assert property (@(posedge clk) disable iff (!rst_q_n)
    ds_miss |-> ds_rdata == '0);
endmodule

// File: tb/gpr_file_bench.sv
module gpr_file_bench;
  logic        clk;
  logic        rst_n;
  logic [4:0]  rda_sel, rdb_sel, insn_wsel;
  logic [7:0]  rda_data, rdb_data, insn_wdata, ds_wdata, ds_rdata;
  logic        insn_we, ptr_we, ds_re, ds_we, ds_hit, ds_miss;
  logic [1:0]  ptr_wsel;
  logic [15:0] ptr_wdata, ds_addr, ptr_x, ptr_y, ptr_z;

  int n_chk;
  int n_fail;

  gpr_file u_gpr_file (
    .clk (clk), .rst_n (rst_n),
    .rda_sel (rda_sel), .rda_data (rda_data),
    .rdb_sel (rdb_sel), .rdb_data (rdb_data),
    .insn_we (insn_we), .insn_wsel (insn_wsel), .insn_wdata (insn_wdata),
    .ptr_we (ptr_we), .ptr_wsel (ptr_wsel), .ptr_wdata (ptr_wdata),
    .ds_addr (ds_addr), .ds_re (ds_re), .ds_we (ds_we), .ds_wdata (ds_wdata),
    .ds_rdata (ds_rdata), .ds_hit (ds_hit), .ds_miss (ds_miss),
    .ptr_x (ptr_x), .ptr_y (ptr_y), .ptr_z (ptr_z)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic idle();
    insn_we = 1'b0; ptr_we = 1'b0; ds_re = 1'b0; ds_we = 1'b0;
  endtask

  function automatic logic [7:0] pat(input int i);
    return 8'(i * 7 + 3);
  endfunction

  task automatic t_reset();
    for (int i = 0; i < 32; i++) begin
      rda_sel = 5'(i);
      #1;
      chk("R1", "reset value", {8'h00, rda_data}, 16'h0000);
    end
  endtask

  task automatic t_insn_write();
    insn_we = 1'b1; insn_wsel = 5'd5; insn_wdata = 8'hA5; rda_sel = 5'd5;
    #1;
    chk("R3", "no bypass before edge", {8'h00, rda_data}, 16'h0000);
    tick();
    idle();
    rdb_sel = 5'd5;
    #1;
    chk("R3", "write visible after edge", {8'h00, rdb_data}, 16'h00A5);
    for (int i = 0; i < 32; i++) begin
      insn_we = 1'b1; insn_wsel = 5'(i); insn_wdata = pat(i);
      tick();
    end
    idle();
    for (int i = 0; i < 32; i++) begin
      rda_sel = 5'(i); rdb_sel = 5'(31 - i);
      #1;
      chk("R2", "port A", {8'h00, rda_data}, {8'h00, pat(i)});
      chk("R2", "port B", {8'h00, rdb_data}, {8'h00, pat(31 - i)});
    end
  endtask

  task automatic t_ptr_view();
    chk("R6", "X pair", ptr_x, {pat(27), pat(26)});
    chk("R6", "Y pair", ptr_y, {pat(29), pat(28)});
    chk("R6", "Z pair", ptr_z, {pat(31), pat(30)});
  endtask

  task automatic t_ds_read();
    ds_re = 1'b1;
    for (int i = 0; i < 32; i += 5) begin
      ds_addr = 16'(i);
      #1;
      chk("R4", "data-space read", {8'h00, ds_rdata}, {8'h00, pat(i)});
      chk("R4", "hit flag", {15'h0, ds_hit}, 16'h0001);
    end
    idle();
  endtask

  task automatic t_ds_write();
    ds_we = 1'b1; ds_addr = 16'd9; ds_wdata = 8'h3C;
    tick();
    idle();
    rda_sel = 5'd9;
    #1;
    chk("R5", "data-space write", {8'h00, rda_data}, 16'h003C);
  endtask

  task automatic t_ptr_write();
    ptr_we = 1'b1; ptr_wsel = 2'd2; ptr_wdata = 16'h1234;
    tick();
    idle();
    rda_sel = 5'd30; rdb_sel = 5'd31;
    #1;
    chk("R7", "Z low byte", {8'h00, rda_data}, 16'h0034);
    chk("R7", "Z high byte", {8'h00, rdb_data}, 16'h0012);
    ptr_we = 1'b1; ptr_wsel = 2'd0; ptr_wdata = 16'hC0DE;
    tick();
    idle();
    #1;
    chk("R7", "X write", ptr_x, 16'hC0DE);
    ptr_we = 1'b1; ptr_wsel = 2'd3; ptr_wdata = 16'hFFFF;
    tick();
    idle();
    #1;
    chk("R7", "sel 3 leaves X", ptr_x, 16'hC0DE);
    chk("R7", "sel 3 leaves Y", ptr_y, {pat(29), pat(28)});
    chk("R7", "sel 3 leaves Z", ptr_z, 16'h1234);
  endtask

  task automatic t_pointer_address();
    ptr_we = 1'b1; ptr_wsel = 2'd2; ptr_wdata = 16'h0007;
    tick();
    idle();
    ds_re = 1'b1; ds_addr = ptr_z;
    #1;
    chk("R4", "pointer aimed at register 7", {8'h00, ds_rdata}, {8'h00, pat(7)});
    idle();
  endtask

  task automatic t_conflict();
    insn_we = 1'b1; insn_wsel = 5'd12; insn_wdata = 8'h11;
    ds_we = 1'b1; ds_addr = 16'd12; ds_wdata = 8'h22;
    tick();
    idle();
    rda_sel = 5'd12;
    #1;
    chk("R8", "insn beats data-space", {8'h00, rda_data}, 16'h0011);
    ptr_we = 1'b1; ptr_wsel = 2'd2; ptr_wdata = 16'hBEEF;
    insn_we = 1'b1; insn_wsel = 5'd31; insn_wdata = 8'h55;
    tick();
    idle();
    #1;
    chk("R8", "insn beats pointer high, pointer low kept", ptr_z, 16'h55EF);
    ptr_we = 1'b1; ptr_wsel = 2'd0; ptr_wdata = 16'h0102;
    ds_we = 1'b1; ds_addr = 16'd26; ds_wdata = 8'h77;
    tick();
    idle();
    #1;
    chk("R8", "pointer beats data-space", ptr_x, 16'h0102);
  endtask

  task automatic t_miss();
    ds_we = 1'b1; ds_addr = 16'd44; ds_wdata = 8'hFF;
    #1;
    chk("R9", "miss flag on write", {15'h0, ds_miss}, 16'h0001);
    chk("R9", "no hit on write", {15'h0, ds_hit}, 16'h0000);
    tick();
    idle();
    rda_sel = 5'd12;
    #1;
    chk("R9", "aliased register unchanged", {8'h00, rda_data}, 16'h0011);
    ds_re = 1'b1; ds_addr = 16'h0100;
    #1;
    chk("R9", "miss read data", {8'h00, ds_rdata}, 16'h0000);
    chk("R9", "miss flag on read", {15'h0, ds_miss}, 16'h0001);
    idle();
  endtask

  initial begin
    #(200000 * 20);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0;
    idle();
    rda_sel = '0; rdb_sel = '0; insn_wsel = '0; insn_wdata = '0;
    ptr_wsel = '0; ptr_wdata = '0; ds_addr = '0; ds_wdata = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();
    t_reset();
    t_insn_write();
    t_ptr_view();
    t_ds_read();
    t_ds_write();
    t_ptr_write();
    t_pointer_address();
    t_conflict();
    t_miss();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule